// File: doc/BRIEF.md
# Auto-Incrementing Serial-to-Parallel Latch Bank

This block collects a serial bit stream into a bank of one-bit entries and presents the whole bank as a parallel word. Each write goes to the entry named by an internal write pointer. The pointer steps forward once for each high-to-low transition seen on a separate advance input, and wraps from the last entry back to entry 0. The host therefore never drives an address: it strobes a bit in, pulses the advance line, and repeats.

A sticky full indication goes low once a write lands in the last entry. It stays low until the master reset, and a pointer wrap does not release it. The flag is active-low so that several banks can share one line as a wired-OR. The parallel output models a three-state bus as a data vector plus a per-bit output enable, under an active-low output-enable input. Everything runs on one clock. The strobe is sampled as a level, so each clock cycle with the strobe high rewrites the selected entry. The advance input is edge-detected against its value at the previous clock edge.

Top module: `serial_latch_bank`

## Requirements
- R1: While `rst_ni` is low, every entry reads 0, the pointer is 0 and `full_no` is 1. Reset acts asynchronously and overrides strobe and advance.
- R2: At a rising clock edge with `strobe_i` high, the entry selected by the pointer takes the value of `data_i`. No other entry changes.
- R3: At a rising clock edge with `strobe_i` low, no entry changes, whatever `data_i` and `incr_i` do.
- R4: The pointer advances by one at a clock edge where `incr_i` is 0 and `incr_i` was 1 at the previous edge. Holding `incr_i` at 1 or at 0 for any number of cycles does not move it.
- R5: When the pointer is at N_ENTRIES-1, the next advance returns it to 0.
- R6: `full_no` falls at the clock edge where a strobe writes while the pointer is N_ENTRIES-1. It stays 0 until reset, including across pointer wraps and later writes.
- R7: `bus_oe_o` is all ones while `enable_ni` is 0 and all zeros while `enable_ni` is 1, with no clock delay. `bus_o` carries the stored entries whatever the value of `enable_ni`.
- R8: If a strobe and an advance fall on the same clock edge, the write goes to the entry the pointer held before that edge.
- R9: Pointer value k selects bit k of `bus_o`. Bit 0 is the first entry written after reset, and the most significant pointer bit selects the upper half of the bank.
- R10: A reset applied partway through a fill clears all entries, the pointer and the full flag. The next strobe after reset writes bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| data_i | input | 1 | Serial data bit |
| strobe_i | input | 1 | Write strobe, level-sampled each clock |
| incr_i | input | 1 | Pointer advance; acts on its falling transition |
| enable_ni | input | 1 | Output enable for the parallel bus, active low |
| bus_o | output | N_ENTRIES | Stored entries, bit k is entry k |
| bus_oe_o | output | N_ENTRIES | Per-bit output enable for the bus |
| full_no | output | 1 | Sticky full flag, active low |

## Verification
The bench builds the bank with its default of eight entries and a three-bit pointer. At that size a complete fill, the wrap from 7 back to 0 and the full transition all fit in a few dozen cycles, so the full flag can be compared at every write from entry 0 to entry 7 and again after the wrap. The small width also lets a reference model in the bench predict the whole bus after every edge. Its pattern covers same-edge strobe and advance, a long high hold on the advance input, and a reset partway through a fill.

// File: rtl/sl_pkg.sv
package sl_pkg;
  function automatic int unsigned ptr_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sl_edge_det.sv
module sl_edge_det #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic pulse_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse_o = sig_q & ~sig_i;
    end else begin : g_rise
      assign pulse_o = ~sig_q & sig_i;
    end
  endgenerate
endmodule

// File: rtl/sl_addr_ctr.sv
module sl_addr_ctr #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AW        = sl_pkg::ptr_width(N_ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(N_ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + AW'(1);
  end
endmodule

// File: rtl/sl_store.sv
module sl_store #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AW        = sl_pkg::ptr_width(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        ptr_i,
  input  logic                 din_i,
  output logic [N_ENTRIES-1:0] q_o
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    logic sel;
    assign sel = we_i && (ptr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_o[i] <= 1'b0;
      else if (sel) q_o[i] <= din_i;
    end
  end
endmodule

// File: rtl/sl_full.sv
module sl_full #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AW        = sl_pkg::ptr_width(N_ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] ptr_i,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST = AW'(N_ENTRIES - 1);

  // sticky: only reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        full_o <= 1'b0;
    else if (we_i && (ptr_i == LAST))   full_o <= 1'b1;
  end
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank #(
  parameter int unsigned N_ENTRIES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 data_i,
  input  logic                 strobe_i,
  input  logic                 incr_i,
  input  logic                 enable_ni,
  output logic [N_ENTRIES-1:0] bus_o,
  output logic [N_ENTRIES-1:0] bus_oe_o,
  output logic                 full_no
);
  localparam int unsigned AW = sl_pkg::ptr_width(N_ENTRIES);

  logic          adv;
  logic [AW-1:0] ptr;
  logic          full;

  sl_edge_det #(.FALLING(1'b1)) i_incr_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (incr_i),
    .pulse_o(adv)
  );

  sl_addr_ctr #(.N_ENTRIES(N_ENTRIES), .AW(AW)) i_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .ptr_o (ptr)
  );

  // write uses the pointer value before any same-edge advance
  sl_store #(.N_ENTRIES(N_ENTRIES), .AW(AW)) i_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (strobe_i),
    .ptr_i (ptr),
    .din_i (data_i),
    .q_o   (bus_o)
  );

  sl_full #(.N_ENTRIES(N_ENTRIES), .AW(AW)) i_full (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (strobe_i),
    .ptr_i (ptr),
    .full_o(full)
  );

  assign full_no  = ~full;
  assign bus_oe_o = {N_ENTRIES{~enable_ni}};
endmodule

// File: rtl/sl_bank_chk.sv
module sl_bank_chk #(
  parameter int unsigned N_ENTRIES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 strobe_i,
  input logic                 enable_ni,
  input logic [N_ENTRIES-1:0] bus_o,
  input logic [N_ENTRIES-1:0] bus_oe_o,
  input logic                 full_no
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (bus_o == '0 && full_no)); // R1

  AST_ONE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ($countones(bus_o ^ $past(bus_o)) <= 1)); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(bus_o)); // R3

  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |=> !full_no); // R6

  AST_FULL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_no) |-> $past(strobe_i)); // R6

  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_ni |-> (bus_oe_o == '0)); // R7

  AST_OE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_ni |-> (&bus_oe_o)); // R7
endmodule

bind serial_latch_bank sl_bank_chk #(.N_ENTRIES(N_ENTRIES)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .enable_ni(enable_ni),
  .bus_o    (bus_o),
  .bus_oe_o (bus_oe_o),
  .full_no  (full_no)
);

// File: tb/test_serial_latch_bank.sv
`timescale 1ns/1ps
module test_serial_latch_bank;
  localparam int N = 8;

  typedef struct {
    logic [N-1:0] bus;
    logic         full_n;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic data_i = 1'b0, strobe_i = 1'b0, incr_i = 1'b0, enable_ni = 1'b1;
  logic [N-1:0] bus_o, bus_oe_o;
  logic full_no;

  serial_latch_bank #(.N_ENTRIES(N)) i_serial_latch_bank (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .strobe_i(strobe_i),
    .incr_i(incr_i), .enable_ni(enable_ni), .bus_o(bus_o),
    .bus_oe_o(bus_oe_o), .full_no(full_no)
  );

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  // reference model
  logic [N-1:0] m_bus = '0;
  int           m_ptr = 0;
  logic         m_full = 1'b0;
  logic         m_incr_q = 1'b0;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bus = '0; m_ptr = 0; m_full = 1'b0; m_incr_q = 1'b0;
  endtask

  // driver: apply one cycle of stimulus, advance model, queue the expectation
  task automatic step(input logic s, input logic d, input logic inc, input string tag);
    @(negedge clk);
    strobe_i = s; data_i = d; incr_i = inc;
    @(posedge clk);
    if (s) begin
      m_bus[m_ptr] = d;
      if (m_ptr == N-1) m_full = 1'b1;
    end
    if (m_incr_q && !inc) m_ptr = (m_ptr == N-1) ? 0 : m_ptr + 1;
    m_incr_q = inc;
    sb.push_back('{bus: m_bus, full_n: ~m_full, tag: tag});
  endtask

  task automatic advance(input string tag);
    step(1'b0, 1'b0, 1'b1, tag);
    step(1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " bus"}, bus_o, e.bus);
      check({e.tag, " full_no"}, {{(N-1){1'b0}}, full_no}, {{(N-1){1'b0}}, e.full_n});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [N-1:0] PAT = 8'b1011_0101;

  initial begin
    #1 rst_ni = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset bus", bus_o, '0);
    check("R1 reset full", {7'b0, full_no}, 8'd1);
    rst_ni = 1'b1;

    // R7 enable control, combinational
    enable_ni = 1'b0; #0.5;
    check("R7 oe on", bus_oe_o, '1);
    enable_ni = 1'b1; #0.5;
    check("R7 oe off", bus_oe_o, '0);

    // R2 R9 R4 R6: serial fill, full checked at every write
    for (int k = 0; k < N; k++) begin
      step(1'b1, PAT[k], 1'b0, "R2 R9 fill write");
      if (k != N-1) advance("R4 advance");
    end
    step(1'b0, 1'b1, 1'b0, "R6 full after last write");
    @(negedge clk);
    enable_ni = 1'b1; #0.5;
    check("R7 bus kept while disabled", bus_o, PAT);
    enable_ni = 1'b0;

    // R3: toggling data and holding incr high with no strobe
    step(1'b0, 1'b0, 1'b1, "R3 no strobe");
    step(1'b0, 1'b1, 1'b1, "R3 no strobe");
    step(1'b0, 1'b0, 1'b1, "R3 no strobe");
    // R4: long high hold, then release -> one advance only, wrap R5
    step(1'b0, 1'b0, 1'b0, "R5 wrap");
    step(1'b1, 1'b0, 1'b0, "R5 write entry0 after wrap");
    step(1'b1, 1'b1, 1'b0, "R6 full stays after wrap");
    // R8: strobe with same-edge advance writes old pointer (entry 0)
    step(1'b0, 1'b0, 1'b1, "R8 prep");
    step(1'b1, 1'b0, 1'b0, "R8 same edge write");
    step(1'b1, 1'b0, 1'b0, "R8 next write entry1");

    // R10: mid-fill reset
    @(negedge clk);
    rst_ni = 1'b0; model_reset();
    #0.5;
    check("R10 mid reset bus", bus_o, '0);
    check("R10 mid reset full", {7'b0, full_no}, 8'd1);
    @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    step(1'b1, 1'b1, 1'b0, "R10 first write after reset");
    advance("R10 advance");
    step(1'b1, 1'b1, 1'b0, "R10 second write");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule